// File: doc/BRIEF.md
# Programmable Up-Counting Timer Core

This block is a 32-bit up-counter for general timekeeping inside a larger chip. Software sets it up through a small register window reached over a single-cycle read/write bus with byte offsets. The counter can advance on every functional clock cycle or once every 2^(v+1) cycles when the prescaler is enabled. When it leaves the all-ones value, the counter either stops (one-shot) or reloads from a load register (auto-reload). Software can also write the counter directly. A write of any data to the trigger offset copies the load register into the counter.

A compare unit raises a flag when the counter reaches a programmed match value. An external capture strobe latches the counter value. All three events set sticky status flags, which software clears by writing ones. Two separately masked views of those flags drive a registered interrupt output and a registered wakeup output.

Top module: `tmr32_core`

## Requirements
- R1: After reset, the control, counter, load, match, status, interrupt-enable and wakeup-enable registers are zero, and `irq` and `wake` are low.
- R2: While control bit 0 (run) is set and the prescaler is off, the counter rises by one on every clock edge, starting with the edge after the one that set the bit. While run is clear, the counter holds its value.
- R3: With control bit 5 set (prescaler on) and bits 4:2 holding v, the counter rises once every 2^(v+1) cycles. The first step comes 2^(v+1) edges after run is set.
- R4: With control bit 1 clear, the edge that advances the counter out of 0xFFFFFFFF loads 0 into the counter, clears control bit 0 and sets status bit 1.
- R5: With control bit 1 set, the edge that advances the counter out of 0xFFFFFFFF loads the load register (offset 0x2C) into the counter, keeps the counter running and sets status bit 1.
- R6: A write of any data to offset 0x30 copies the load register into the counter on that edge. A write to offset 0x28 puts the written value into the counter on that edge. Either write takes priority over counting.
- R7: With control bit 6 set, an edge that advances the counter to the value at offset 0x38 sets status bit 0. With bit 6 clear, no match flag is raised.
- R8: Status (offset 0x18) bits stay set until a write to that offset has a one in their position. Bits written with zero are unaffected. A hardware event in the same cycle as a clearing write leaves its bit set.
- R9: `irq` is high one cycle after any status bit is set whose bit is also set at offset 0x1C. `wake` behaves the same way with the mask at offset 0x20.
- R10: A high `cap_in` at a clock edge copies the counter into the capture register (offset 0x3C) and sets status bit 2.
- R11: A read returns data on `bus_rdata` one cycle after `bus_re`. Control reads return bits 6:0 with the upper bits zero, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 1 | Capture strobe |
| irq | output | 1 | Masked event request |
| wake | output | 1 | Masked wakeup request |

## Verification
Several properties are checked on every cycle by the bound checker:
- a stopped counter holds its value, and a trigger write loads the load value;
- the one-shot and auto-reload overflow outcomes;
- status flags stay set unless a one is written to clear them;
- the interrupt rises only when some enable bit was set;
- reset leaves the outputs quiet.

Other behaviour needs the bench's scenarios, because each check depends on a count of elapsed cycles or on a sequence of writes and reads:
- the prescaler's stepping rate;
- the exact counter values after a given number of cycles;
- the match flag and its suppression when compare is disabled;
- the capture value;
- the read-back map.

// File: rtl/tmr32_pkg.sv
package tmr32_pkg;
  localparam int AW     = 8;
  localparam int PSV_W  = 3;
  localparam int CTRL_W = 7;
  localparam int NFL    = 3;

  localparam logic [AW-1:0] OFS_STAT  = 8'h18;
  localparam logic [AW-1:0] OFS_IEN   = 8'h1C;
  localparam logic [AW-1:0] OFS_WEN   = 8'h20;
  localparam logic [AW-1:0] OFS_CTRL  = 8'h24;
  localparam logic [AW-1:0] OFS_CNT   = 8'h28;
  localparam logic [AW-1:0] OFS_LOAD  = 8'h2C;
  localparam logic [AW-1:0] OFS_TRIG  = 8'h30;
  localparam logic [AW-1:0] OFS_MATCH = 8'h38;
  localparam logic [AW-1:0] OFS_CAPT  = 8'h3C;

  localparam int FL_MATCH = 0;
  localparam int FL_OVF   = 1;
  localparam int FL_CAPT  = 2;

  // field order is the bit order of the control word (bit 0 last)
  typedef struct packed {
    logic             cmp_en;
    logic             ps_en;
    logic [PSV_W-1:0] ps_val;
    logic             auto_rl;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr32_prescale.sv
module tmr32_prescale #(
  parameter int PSV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ps_en,
  input  logic [PSV_W-1:0] ps_val,
  output logic             tick
);
  localparam int PS_W = 1 << PSV_W;

  logic [PS_W-1:0] div_q;
  logic [PS_W:0]   lim_w;
  logic            wrap_w;

  always_comb begin
    lim_w  = (((PS_W+1)'(1)) << ps_val << 1) - (PS_W+1)'(1);
    wrap_w = ({1'b0, div_q} == lim_w);
    tick   = run && (!ps_en || wrap_w);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !ps_en) div_q <= '0;
    else if (wrap_w)           div_q <= '0;
    else                       div_q <= div_q + PS_W'(1);
  end
endmodule

// File: rtl/tmr32_count.sv
module tmr32_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load,
  input  logic [CNT_W-1:0] match,
  input  logic             wr_cnt,
  input  logic             trig,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_match,
  output logic             ev_ovf,
  output logic             stop_req
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt      = cnt;
    ev_match = 1'b0;
    ev_ovf   = 1'b0;
    stop_req = 1'b0;
    if (trig) begin
      nxt = load;
    end else if (wr_cnt) begin
      nxt = wr_val;
    end else if (tick) begin
      if (&cnt) begin
        ev_ovf   = 1'b1;
        stop_req = !auto_rl;
        nxt      = auto_rl ? load : '0;
      end else begin
        nxt = cnt + CNT_W'(1);
      end
      ev_match = cmp_en && (nxt == match);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/tmr32_regs.sv
module tmr32_regs
  import tmr32_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ev_match,
  input  logic             ev_ovf,
  input  logic             stop_req,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] match,
  output logic [NFL-1:0]   stat,
  output logic [NFL-1:0]   ien,
  output logic             wr_cnt,
  output logic             trig,
  output logic             irq,
  output logic             wake
);
  logic [CNT_W-1:0] capt;
  logic [NFL-1:0]   wen, set_w, clr_w;

  always_comb begin
    wr_cnt = bus_we && (bus_addr == OFS_CNT);
    trig   = bus_we && (bus_addr == OFS_TRIG);
    set_w  = '0;
    set_w[FL_MATCH] = ev_match;
    set_w[FL_OVF]   = ev_ovf;
    set_w[FL_CAPT]  = cap_in;
    clr_w  = (bus_we && bus_addr == OFS_STAT) ? bus_wdata[NFL-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      load  <= '0;
      match <= '0;
      ien   <= '0;
      wen   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_CTRL:  ctrl  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        OFS_LOAD:  load  <= bus_wdata;
        OFS_MATCH: match <= bus_wdata;
        OFS_IEN:   ien   <= bus_wdata[NFL-1:0];
        OFS_WEN:   wen   <= bus_wdata[NFL-1:0];
        default: ;
      endcase
      if (stop_req && bus_addr != OFS_CTRL) ctrl.run <= 1'b0;
    end else if (stop_req) begin
      ctrl.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      capt <= '0;
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      stat <= (stat & ~clr_w) | set_w;
      if (cap_in) capt <= cnt;
      irq  <= |(stat & ien);
      wake <= |(stat & wen);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        OFS_STAT:  bus_rdata <= CNT_W'(stat);
        OFS_IEN:   bus_rdata <= CNT_W'(ien);
        OFS_WEN:   bus_rdata <= CNT_W'(wen);
        OFS_CTRL:  bus_rdata <= CNT_W'(ctrl);
        OFS_CNT:   bus_rdata <= cnt;
        OFS_LOAD:  bus_rdata <= load;
        OFS_MATCH: bus_rdata <= match;
        OFS_CAPT:  bus_rdata <= capt;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr32_core.sv
module tmr32_core
  import tmr32_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_in,
  output logic             irq,
  output logic             wake
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, load, match;
  logic [NFL-1:0]   stat, ien;
  logic             tick, ev_match, ev_ovf, stop_req, wr_cnt, trig;
  logic             ctl_run, ctl_ar;

  assign ctl_run = ctrl.run;
  assign ctl_ar  = ctrl.auto_rl;

  tmr32_prescale #(.PSV_W(PSV_W)) u_ps (
    .clk(clk), .rst(rst), .run(ctrl.run), .ps_en(ctrl.ps_en),
    .ps_val(ctrl.ps_val), .tick(tick)
  );

  tmr32_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .auto_rl(ctrl.auto_rl),
    .cmp_en(ctrl.cmp_en), .load(load), .match(match), .wr_cnt(wr_cnt),
    .trig(trig), .wr_val(bus_wdata), .cnt(cnt), .ev_match(ev_match),
    .ev_ovf(ev_ovf), .stop_req(stop_req)
  );

  tmr32_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cnt(cnt), .ev_match(ev_match), .ev_ovf(ev_ovf),
    .stop_req(stop_req), .ctrl(ctrl), .load(load), .match(match),
    .stat(stat), .ien(ien), .wr_cnt(wr_cnt), .trig(trig),
    .irq(irq), .wake(wake)
  );
endmodule

// File: rtl/tmr32_check.sv
module tmr32_check
  import tmr32_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             irq,
  input logic             wake,
  input logic             run,
  input logic             ar,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic [NFL-1:0]   stat,
  input logic [NFL-1:0]   ien
);
  logic [NFL-1:0] keep;
  logic           cnt_touch;
  assign keep      = stat & ~((bus_we && bus_addr == OFS_STAT) ? bus_wdata[NFL-1:0] : '0);
  assign cnt_touch = bus_we && (bus_addr == OFS_CNT || bus_addr == OFS_TRIG);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (stat == '0 && !irq && !wake));

  // R2
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_touch) |=> (cnt == $past(cnt)));

  // R4
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (run && !ar && tick && (&cnt) && !bus_we) |=> (!run && cnt == '0 && stat[FL_OVF]));

  // R5
  a_r5_autoreload: assert property (@(posedge clk) disable iff (rst)
    (run && ar && tick && (&cnt) && !bus_we) |=> (run && cnt == $past(load) && stat[FL_OVF]));

  // R6
  a_r6_trigger_loads: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_TRIG) |=> (cnt == $past(load)));

  // R8
  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & $past(keep)) == $past(keep)));

  // R9
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ien) != '0));
endmodule

bind tmr32_core tmr32_check #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .wake(wake), .run(ctl_run),
  .ar(ctl_ar), .tick(tick), .cnt(cnt), .load(load), .stat(stat), .ien(ien)
);

// File: tb/sim_tmr32_core.sv
`timescale 1ns/1ps
module sim_tmr32_core;
  logic        clk = 0, rst = 1, bus_we = 0, bus_re = 0, cap_in = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, v, w;
  logic        irq, wake;
  int          errs = 0, nchk = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  tmr32_core u0 (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .irq(irq), .wake(wake));

  localparam logic [7:0] A_STAT = 8'h18, A_IEN = 8'h1C, A_WEN = 8'h20,
    A_CTRL = 8'h24, A_CNT = 8'h28, A_LOAD = 8'h2C, A_TRIG = 8'h30,
    A_MATCH = 8'h38, A_CAPT = 8'h3C;

  typedef struct packed { logic rd; logic [7:0] a; logic [31:0] d; } step_t;
  localparam int NSTEP = 13;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 8'h2C, 32'h0000_0100}, '{1'b1, 8'h2C, 32'h0000_0100},
    '{1'b0, 8'h30, 32'h0000_DEAD}, '{1'b1, 8'h28, 32'h0000_0100},
    '{1'b0, 8'h28, 32'h0000_0055}, '{1'b1, 8'h28, 32'h0000_0055},
    '{1'b0, 8'h38, 32'h0000_ABCD}, '{1'b1, 8'h38, 32'h0000_ABCD},
    '{1'b0, 8'h24, 32'hFFFF_FF7E}, '{1'b1, 8'h24, 32'h0000_007E},
    '{1'b0, 8'h24, 32'h0000_0000}, '{1'b1, 8'h34, 32'h0000_0000},
    '{1'b1, 8'h1C, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CNT, v);  check("R1 counter", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wake", {31'b0, wake}, 0);

    // R6 / R11 register table
    for (int i = 0; i < NSTEP; i++) begin
      if (TBL[i].rd) begin
        rd(TBL[i].a, v);
        check($sformatf("R11 R6 table step %0d", i), v, TBL[i].d);
      end else wr(TBL[i].a, TBL[i].d);
    end

    // R2 free running count, then stop
    wr(A_CNT, 32'd10); wr(A_CTRL, 32'h1);
    rd(A_CNT, v); check("R2 first read", v, 32'd10);
    rd(A_CNT, v); check("R2 second read", v, 32'd11);
    idle(4);
    rd(A_CNT, v); check("R2 after idle", v, 32'd16);
    wr(A_CTRL, 0);
    rd(A_CNT, v); rd(A_CNT, w); check("R2 stopped holds", w, v);

    // R3 prescaler v=1 -> one step per 4 cycles
    wr(A_CNT, 0); wr(A_CTRL, 32'h25);
    rd(A_CNT, v); check("R3 no early step", v, 0);
    idle(7);
    rd(A_CNT, v); check("R3 two steps", v, 32'd2);
    wr(A_CTRL, 0);

    // R4 one-shot overflow
    wr(A_STAT, 7); wr(A_IEN, 2); wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTRL, 1);
    idle(4);
    rd(A_CNT, v);  check("R4 counter wraps to zero", v, 0);
    rd(A_CTRL, v); check("R4 run cleared", v, 0);
    rd(A_STAT, v); check("R4 overflow flag", v, 2);
    check("R9 irq on overflow", {31'b0, irq}, 1);
    check("R9 wake masked", {31'b0, wake}, 0);
    wr(A_STAT, 2); idle(1);
    check("R9 irq drops", {31'b0, irq}, 0);
    rd(A_STAT, v); check("R8 cleared", v, 0);

    // R5 auto-reload
    wr(A_LOAD, 32'h1000_0000); wr(A_WEN, 2); wr(A_CNT, 32'hFFFF_FFFD); wr(A_CTRL, 3);
    idle(5);
    rd(A_CNT, v);  check("R5 reloaded and counting", v, 32'h1000_0002);
    rd(A_CTRL, v); check("R5 still running", v, 3);
    rd(A_STAT, v); check("R5 overflow flag", v, 2);
    check("R9 wake on overflow", {31'b0, wake}, 1);
    wr(A_CTRL, 0); wr(A_STAT, 7); wr(A_WEN, 0);

    // R7 compare match, then compare disabled
    wr(A_IEN, 1); wr(A_CNT, 32'h20); wr(A_MATCH, 32'h23); wr(A_CTRL, 32'h41);
    idle(5); wr(A_CTRL, 0);
    rd(A_STAT, v); check("R7 match flag", v, 1);
    check("R9 irq on match", {31'b0, irq}, 1);
    wr(A_STAT, 7);
    wr(A_CNT, 32'h20); wr(A_CTRL, 1); idle(5); wr(A_CTRL, 0);
    rd(A_STAT, v); check("R7 no flag when compare off", v, 0);

    // R10 capture
    wr(A_CNT, 32'h77);
    cap_in = 1; @(negedge clk); cap_in = 0;
    rd(A_CAPT, v); check("R10 captured value", v, 32'h77);
    rd(A_STAT, v); check("R10 capture flag", v, 4);

    // R8 partial clear
    wr(A_CNT, 32'h20); wr(A_CTRL, 32'h41); idle(5); wr(A_CTRL, 0);
    rd(A_STAT, v); check("R8 two flags", v, 5);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R8 zero bits kept", v, 4);
    wr(A_STAT, 4);

    // R8 set wins over clear in the same cycle
    cap_in = 1; bus_we = 1; bus_addr = A_STAT; bus_wdata = 4;
    @(negedge clk);
    cap_in = 0; bus_we = 0;
    rd(A_STAT, v); check("R8 set wins", v, 4);

    // R6 trigger while running
    wr(A_LOAD, 32'h500); wr(A_CTRL, 1); wr(A_TRIG, 32'h1234);
    rd(A_CNT, v); check("R6 trigger reload", v, 32'h500);
    wr(A_CTRL, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule